// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store for a 32-bit load/store core with seven processor modes. Software names sixteen logical registers with a 4-bit number. The current mode decides which physical copy a logical number reaches. Registers 0 to 7 are one set shared by every mode. Registers 8 to 14 may instead reach a copy private to the mode. Logical register 15 is the program counter, which the block also holds.

Two read ports return their values in the same cycle as the address. One write port, fed by the execute stage, commits at the clock edge. The block also keeps the current status word. Bits 4:0 of that word hold the mode and bit 5 selects the compressed 16-bit instruction state. Each exception mode has its own saved status word, and one port reads or writes the saved word of the current mode. A fetch-advance strobe steps the program counter by the instruction size of the current state.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0x00000013 (supervisor, 32-bit state), all general registers and saved status words are zero, the program counter is zero, and register 15 reads as 8.
- R2: Logical registers 0 to 7 reach the same storage in every mode: a value written in one mode reads back unchanged in any other.
- R3: Fast-interrupt mode (mode code 10001) has private copies of registers 8 to 14. Writes there leave the copies of the other modes unchanged, and its copies start at zero.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private copies of registers 13 and 14 only. Their registers 8 to 12 are the user-mode registers.
- R5: System mode (11111) reaches exactly the user-mode (10000) registers. Any other mode code is treated as user mode for register mapping and has no saved status word.
- R6: Each of the five exception modes has its own saved status word, read and written through the saved-status port. In user or system mode the port reads zero and a write there changes no saved word.
- R7: A read of register 15 returns the program counter plus 8 in 32-bit state and plus 4 when status bit 5 is set.
- R8: With the advance strobe high and no write to register 15, the program counter grows by 4 in 32-bit state or by 2 in compressed state. With neither strobe nor write, it holds its value.
- R9: A write to register 15 loads the program counter with bits 1:0 cleared in 32-bit state, or bit 0 cleared in compressed state. It takes priority over an advance in the same cycle.
- R10: Both read ports return data combinationally for any pair of addresses. A write shows from the next cycle on, and a read of the written register in the write cycle returns the old value.
- R11: A status-word write takes effect in the next cycle, and the mode it holds then steers the register mapping and saved-word selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write-port enable |
| wr_idx | input | 4 | Logical register number for the write port |
| wr_data | input | 32 | Write-port data |
| pc_adv | input | 1 | Advance the program counter by one instruction |
| status_wr_en | input | 1 | Load the current status word |
| status_wr_data | input | 32 | New current status word |
| status_q | output | 32 | Current status word |
| saved_wr_en | input | 1 | Write the current mode's saved status word |
| saved_wr_data | input | 32 | Data for the saved status word |
| saved_rd_data | output | 32 | Current mode's saved status word, zero when none |

## Verification
A wrong bank mapping leaves no mark until the disturbed copy is read in the mode that owns it. The scenarios therefore write a register in one mode and read it back after each mode change: fast interrupt, interrupt, system and an undefined mode code. A saved word that is stored under the wrong mode, or accepted in user or system mode, shows only when the proper exception mode reads its slot, so every slot is read again after the ignored writes. Program counter faults show one cycle after the advance or write, on the register 15 offset of either read port, in both instruction states.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   localparam int MODE_W    = 5;
   localparam int LIDX_W    = 4;
   localparam int SHARED_N  = 15;               // user copies of logical 0..14
   localparam int FIQ_BASE  = SHARED_N;         // fast-interrupt copies of 8..14
   localparam int FIQ_N     = 7;
   localparam int IRQ_BASE  = FIQ_BASE + FIQ_N; // two-register banks follow
   localparam int PAIR_N    = 2;
   localparam int SVC_BASE  = IRQ_BASE + PAIR_N;
   localparam int ABT_BASE  = SVC_BASE + PAIR_N;
   localparam int UND_BASE  = ABT_BASE + PAIR_N;
   localparam int NUM_PHYS  = UND_BASE + PAIR_N;
   localparam int PHYS_W    = $clog2(NUM_PHYS);
   localparam int NUM_SAVED = 5;
   localparam int SLOT_W    = 3;
   localparam logic [SLOT_W-1:0] NO_SLOT = '1;
   localparam logic [LIDX_W-1:0] PC_IDX  = 4'd15;

   typedef enum logic [MODE_W-1:0] {
      M_USR = 5'b10000,
      M_FIQ = 5'b10001,
      M_IRQ = 5'b10010,
      M_SVC = 5'b10011,
      M_ABT = 5'b10111,
      M_UND = 5'b11011,
      M_SYS = 5'b11111
   } mode_e;

   function automatic logic [PHYS_W-1:0] phys_of(input logic [MODE_W-1:0] mode,
                                                 input logic [LIDX_W-1:0] lidx);
      logic [PHYS_W-1:0] base;
      logic              upper;
      base  = PHYS_W'(lidx);
      upper = (lidx == 4'd14);
      if (mode == M_FIQ && lidx >= 4'd8 && lidx <= 4'd14) begin
         base = PHYS_W'(lidx) + PHYS_W'(FIQ_BASE - 8);
      end else if (lidx == 4'd13 || lidx == 4'd14) begin
         case (mode)
            M_IRQ:   base = PHYS_W'(IRQ_BASE) + PHYS_W'(upper);
            M_SVC:   base = PHYS_W'(SVC_BASE) + PHYS_W'(upper);
            M_ABT:   base = PHYS_W'(ABT_BASE) + PHYS_W'(upper);
            M_UND:   base = PHYS_W'(UND_BASE) + PHYS_W'(upper);
            default: base = PHYS_W'(lidx);
         endcase
      end
      return base;
   endfunction

   function automatic logic [SLOT_W-1:0] slot_of(input logic [MODE_W-1:0] mode);
      logic [SLOT_W-1:0] s;
      case (mode)
         M_FIQ:   s = 3'd0;
         M_IRQ:   s = 3'd1;
         M_SVC:   s = 3'd2;
         M_ABT:   s = 3'd3;
         M_UND:   s = 3'd4;
         default: s = NO_SLOT;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/regbank_map.sv
module regbank_map
   import regbank_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic [LIDX_W-1:0] lidx,
   output logic [PHYS_W-1:0] phys
);

   always_comb begin
      phys = phys_of(mode, lidx);
   end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
   parameter int XLEN   = 32,
   parameter int NPHYS  = 30,
   parameter int PHYS_W = $clog2(NPHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PHYS_W-1:0] wr_phys,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [PHYS_W-1:0] rd_a_phys,
   input  logic [PHYS_W-1:0] rd_b_phys,
   output logic [XLEN-1:0]   rd_a_val,
   output logic [XLEN-1:0]   rd_b_val
);

   logic [XLEN-1:0] cells [NPHYS];

   for (genvar g = 0; g < NPHYS; g++) begin : g_cell
      logic [XLEN-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  cell_q <= '0;
         else if (wr_en && wr_phys == PHYS_W'(g))     cell_q <= wr_data;
      end
      assign cells[g] = cell_q;
   end

   assign rd_a_val = (rd_a_phys < PHYS_W'(NPHYS)) ? cells[rd_a_phys] : '0;
   assign rd_b_val = (rd_b_phys < PHYS_W'(NPHYS)) ? cells[rd_b_phys] : '0;

endmodule

// File: rtl/regbank_psr.sv
module regbank_psr
   import regbank_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter logic [XLEN-1:0] STATUS_RESET = 32'h0000_0013
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            status_wr_en,
   input  logic [XLEN-1:0] status_wr_data,
   input  logic            saved_wr_en,
   input  logic [XLEN-1:0] saved_wr_data,
   output logic [XLEN-1:0] status_q,
   output logic [XLEN-1:0] saved_rd_data
);

   logic [MODE_W-1:0] mode;
   logic [SLOT_W-1:0] slot;
   logic [XLEN-1:0]   saved_arr [NUM_SAVED];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            status_q <= STATUS_RESET;
      else if (status_wr_en) status_q <= status_wr_data;
   end

   assign mode = status_q[MODE_W-1:0];
   assign slot = slot_of(mode);

   for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
      logic [XLEN-1:0] sv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  sv_q <= '0;
         else if (saved_wr_en && slot == SLOT_W'(s))  sv_q <= saved_wr_data;
      end
      assign saved_arr[s] = sv_q;
   end

   assign saved_rd_data = (slot < SLOT_W'(NUM_SAVED)) ? saved_arr[slot] : '0;

   // R11: a status write is what the next cycle shows
   p_status_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      status_wr_en |=> status_q == $past(status_wr_data));

   // R6: user and system modes expose no saved word
   p_saved_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_USR || mode == M_SYS) |-> saved_rd_data == '0);

   // R6: with no write and no mode change, the saved word is steady
   p_saved_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!saved_wr_en && !status_wr_en) |=> $stable(saved_rd_data));

endmodule

// File: rtl/regbank_pc.sv
module regbank_pc #(
   parameter int              XLEN           = 32,
   parameter bit              HAS_COMPRESSED = 1'b1,
   parameter logic [XLEN-1:0] PC_RESET       = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            compressed,
   input  logic            pc_adv,
   input  logic            pc_wr_en,
   input  logic [XLEN-1:0] pc_wr_data,
   output logic [XLEN-1:0] pc_read
);

   logic            short_mode;
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] step;
   logic [XLEN-1:0] ahead;
   logic [XLEN-1:0] aligned;

   if (HAS_COMPRESSED) begin : g_dual_state
      assign short_mode = compressed;
   end else begin : g_wide_only
      assign short_mode = 1'b0;
   end

   assign step    = short_mode ? XLEN'(2) : XLEN'(4);
   assign ahead   = short_mode ? XLEN'(4) : XLEN'(8);
   assign aligned = short_mode ? {pc_wr_data[XLEN-1:1], 1'b0}
                               : {pc_wr_data[XLEN-1:2], 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q <= PC_RESET;
      else if (pc_wr_en) pc_q <= aligned;
      else if (pc_adv)   pc_q <= pc_q + step;
   end

   assign pc_read = pc_q + ahead;

   // R8: idle cycles leave the counter alone
   p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_adv && !pc_wr_en) |=> $stable(pc_q));

   // R8: an advance steps by one instruction of the current state
   p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_adv && !pc_wr_en) |=> pc_q == $past(pc_q) + $past(step));

   // R9: a load in 32-bit state lands word aligned
   p_pc_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr_en && !short_mode) |=> pc_q[1:0] == 2'b00);

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import regbank_pkg::*;
#(
   parameter int              XLEN           = 32,
   parameter int              STATE_BIT      = 5,
   parameter bit              HAS_COMPRESSED = 1'b1,
   parameter logic [XLEN-1:0] STATUS_RESET   = 32'h0000_0013,
   parameter logic [XLEN-1:0] PC_RESET       = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   output logic [XLEN-1:0]   rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [XLEN-1:0]   rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [XLEN-1:0]   wr_data,
   input  logic              pc_adv,
   input  logic              status_wr_en,
   input  logic [XLEN-1:0]   status_wr_data,
   output logic [XLEN-1:0]   status_q,
   input  logic              saved_wr_en,
   input  logic [XLEN-1:0]   saved_wr_data,
   output logic [XLEN-1:0]   saved_rd_data
);

   initial begin
      assert (XLEN >= 16)
         else $error("banked_regfile: XLEN must be at least 16");
      assert (STATE_BIT >= MODE_W && STATE_BIT < XLEN)
         else $error("banked_regfile: STATE_BIT must sit above the mode field");
   end

   logic [MODE_W-1:0] mode;
   logic [PHYS_W-1:0] phys_a, phys_b, phys_w;
   logic [XLEN-1:0]   val_a, val_b, pc_read;
   logic              gpr_we, pc_we;

   assign mode   = status_q[MODE_W-1:0];
   assign gpr_we = wr_en && (wr_idx != PC_IDX);
   assign pc_we  = wr_en && (wr_idx == PC_IDX);

   regbank_map u_map_a (.mode(mode), .lidx(rd_a_idx), .phys(phys_a));
   regbank_map u_map_b (.mode(mode), .lidx(rd_b_idx), .phys(phys_b));
   regbank_map u_map_w (.mode(mode), .lidx(wr_idx),   .phys(phys_w));

   regbank_store #(.XLEN(XLEN), .NPHYS(NUM_PHYS), .PHYS_W(PHYS_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (gpr_we),
      .wr_phys   (phys_w),
      .wr_data   (wr_data),
      .rd_a_phys (phys_a),
      .rd_b_phys (phys_b),
      .rd_a_val  (val_a),
      .rd_b_val  (val_b)
   );

   regbank_psr #(.XLEN(XLEN), .STATUS_RESET(STATUS_RESET)) u_psr (
      .clk            (clk),
      .rst_n          (rst_n),
      .status_wr_en   (status_wr_en),
      .status_wr_data (status_wr_data),
      .saved_wr_en    (saved_wr_en),
      .saved_wr_data  (saved_wr_data),
      .status_q       (status_q),
      .saved_rd_data  (saved_rd_data)
   );

   regbank_pc #(.XLEN(XLEN), .HAS_COMPRESSED(HAS_COMPRESSED), .PC_RESET(PC_RESET)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .compressed (status_q[STATE_BIT]),
      .pc_adv     (pc_adv),
      .pc_wr_en   (pc_we),
      .pc_wr_data (wr_data),
      .pc_read    (pc_read)
   );

   assign rd_a_data = (rd_a_idx == PC_IDX) ? pc_read : val_a;
   assign rd_b_data = (rd_b_idx == PC_IDX) ? pc_read : val_b;

   // R10: a general register written last cycle reads back in an unchanged mode
   p_wr_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_idx) != PC_IDX && $stable(mode) && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

   // R2: shared registers read the same through both ports in any mode
   p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

   localparam int XLEN = 32;
   localparam int WATCHDOG_NS = 400000;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [3:0]      rd_a_idx, rd_b_idx, wr_idx;
   logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
   logic            wr_en, pc_adv, status_wr_en, saved_wr_en;
   logic [XLEN-1:0] status_wr_data, status_q, saved_wr_data, saved_rd_data;

   always #2 clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .pc_adv(pc_adv),
      .status_wr_en(status_wr_en), .status_wr_data(status_wr_data), .status_q(status_q),
      .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_rd_data(saved_rd_data)
   );

   // scoreboard entry: which output, its expected value, and the requirement
   typedef struct {
      int              port;   // 0 A, 1 B, 2 saved, 3 status
      logic [XLEN-1:0] exp;
      string           req;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   bit    finished = 1'b0;

   task automatic set_idle();
      wr_en = 1'b0; wr_idx = '0; wr_data = '0; pc_adv = 1'b0;
      status_wr_en = 1'b0; status_wr_data = '0;
      saved_wr_en = 1'b0; saved_wr_data = '0;
      rd_a_idx = '0; rd_b_idx = '0;
   endtask

   task automatic expect_item(input int port, input logic [XLEN-1:0] exp, input string req);
      item_t it;
      it.port = port; it.exp = exp; it.req = req;
      q.push_back(it);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [XLEN-1:0] val);
      @(negedge clk); set_idle();
      wr_en = 1'b1; wr_idx = idx; wr_data = val;
   endtask

   task automatic wr_adv(input logic [3:0] idx, input logic [XLEN-1:0] val);
      @(negedge clk); set_idle();
      wr_en = 1'b1; wr_idx = idx; wr_data = val; pc_adv = 1'b1;
   endtask

   task automatic adv();
      @(negedge clk); set_idle();
      pc_adv = 1'b1;
   endtask

   task automatic set_status(input logic [XLEN-1:0] val);
      @(negedge clk); set_idle();
      status_wr_en = 1'b1; status_wr_data = val;
   endtask

   task automatic saved_wr(input logic [XLEN-1:0] val);
      @(negedge clk); set_idle();
      saved_wr_en = 1'b1; saved_wr_data = val;
   endtask

   task automatic chk_a(input logic [3:0] idx, input logic [XLEN-1:0] exp, input string req);
      @(negedge clk); set_idle();
      rd_a_idx = idx;
      expect_item(0, exp, req);
   endtask

   task automatic chk_b(input logic [3:0] idx, input logic [XLEN-1:0] exp, input string req);
      @(negedge clk); set_idle();
      rd_b_idx = idx;
      expect_item(1, exp, req);
   endtask

   task automatic chk_ab(input logic [3:0] ia, input logic [XLEN-1:0] ea,
                         input logic [3:0] ib, input logic [XLEN-1:0] eb, input string req);
      @(negedge clk); set_idle();
      rd_a_idx = ia; rd_b_idx = ib;
      expect_item(0, ea, req);
      expect_item(1, eb, req);
   endtask

   task automatic chk_saved(input logic [XLEN-1:0] exp, input string req);
      @(negedge clk); set_idle();
      expect_item(2, exp, req);
   endtask

   task automatic chk_status(input logic [XLEN-1:0] exp, input string req);
      @(negedge clk); set_idle();
      expect_item(3, exp, req);
   endtask

   function automatic logic [XLEN-1:0] observe(input int port);
      case (port)
         0:       return rd_a_data;
         1:       return rd_b_data;
         2:       return saved_rd_data;
         default: return status_q;
      endcase
   endfunction

   // monitor: one time unit before the rising edge, compare what the driver queued
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [XLEN-1:0] act;
            it  = q.pop_front();
            act = observe(it.port);
            n_checks++;
            if (act !== it.exp) begin
               n_fails++;
               $display("FAIL %s port=%0d actual=%h expected=%h", it.req, it.port, act, it.exp);
            end
         end
      end
   end

   initial begin
      #(WATCHDOG_NS);
      if (!finished) begin
         n_fails++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      set_idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk_status(32'h0000_0013, "R1");
      chk_a(4'd0, 32'h0, "R1");
      chk_b(4'd15, 32'h8, "R1");
      chk_saved(32'h0, "R1");

      // supervisor mode writes; R10 old value in the write cycle
      wr(4'd3, 32'hA5A5_0003);
      wr(4'd13, 32'h0000_5C13);
      @(negedge clk); set_idle();
      wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0000_0055; rd_a_idx = 4'd5;
      expect_item(0, 32'h0, "R10");
      chk_a(4'd5, 32'h0000_0055, "R10");

      // user mode
      set_status(32'h0000_0010);
      chk_status(32'h0000_0010, "R11");
      chk_a(4'd3, 32'hA5A5_0003, "R2");
      chk_a(4'd13, 32'h0, "R4");
      wr(4'd13, 32'h1111_0013);
      wr(4'd14, 32'h1111_0014);
      wr(4'd8,  32'h8888_0008);
      wr(4'd12, 32'hCCCC_000C);

      // interrupt mode: 8..12 shared, 13 private
      set_status(32'h0000_0012);
      chk_ab(4'd8, 32'h8888_0008, 4'd13, 32'h0, "R4");
      chk_a(4'd12, 32'hCCCC_000C, "R4");
      wr(4'd13, 32'h2222_0013);

      // system mode equals user
      set_status(32'h0000_001F);
      chk_ab(4'd13, 32'h1111_0013, 4'd14, 32'h1111_0014, "R5");

      // fast interrupt: private 8..14
      set_status(32'h0000_0011);
      chk_ab(4'd8, 32'h0, 4'd13, 32'h0, "R3");
      chk_a(4'd3, 32'hA5A5_0003, "R2");
      wr(4'd8, 32'h0000_00F8);
      wr(4'd14, 32'h0000_0F14);
      chk_a(4'd8, 32'h0000_00F8, "R3");
      set_status(32'h0000_0010);
      chk_ab(4'd8, 32'h8888_0008, 4'd14, 32'h1111_0014, "R3");
      set_status(32'h0000_0013);
      chk_a(4'd13, 32'h0000_5C13, "R4");
      set_status(32'h0000_0012);
      chk_a(4'd13, 32'h2222_0013, "R4");

      // R6 saved status words
      saved_wr(32'hCAFE_0012);
      chk_saved(32'hCAFE_0012, "R6");
      set_status(32'h0000_0013);
      chk_saved(32'h0, "R6");
      saved_wr(32'hBEEF_0013);
      chk_saved(32'hBEEF_0013, "R6");
      set_status(32'h0000_0012);
      chk_saved(32'hCAFE_0012, "R6");
      set_status(32'h0000_0010);
      chk_saved(32'h0, "R6");
      saved_wr(32'h0000_1234);
      chk_saved(32'h0, "R6");
      set_status(32'h0000_001F);
      saved_wr(32'h0000_5678);
      chk_saved(32'h0, "R6");
      set_status(32'h0000_0011);
      chk_saved(32'h0, "R6");
      set_status(32'h0000_0012);
      chk_saved(32'hCAFE_0012, "R6");
      set_status(32'h0000_0013);
      chk_saved(32'hBEEF_0013, "R6");

      // R5 undefined mode code acts as user
      set_status(32'h0000_0015);
      chk_a(4'd13, 32'h1111_0013, "R5");
      chk_saved(32'h0, "R5");

      // program counter, 32-bit state
      set_status(32'h0000_0010);
      wr(4'd15, 32'h0000_1003);
      chk_a(4'd15, 32'h0000_1008, "R9");
      adv();
      chk_b(4'd15, 32'h0000_100C, "R8");
      chk_a(4'd15, 32'h0000_100C, "R8");
      // compressed state (bit 5)
      set_status(32'h0000_0030);
      chk_a(4'd15, 32'h0000_1008, "R7");
      wr(4'd15, 32'h0000_2003);
      chk_a(4'd15, 32'h0000_2006, "R9");
      adv();
      chk_a(4'd15, 32'h0000_2008, "R8");
      wr_adv(4'd15, 32'h0000_3001);
      chk_b(4'd15, 32'h0000_3004, "R9");
      set_status(32'h0000_0010);
      chk_a(4'd15, 32'h0000_3008, "R7");

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule